// File: doc/BRIEF.md
# Vertical Charge-Transfer Sequencer

This block produces the vertical shift clock that moves a frame-transfer image sensor's charge matrix, one line per pulse, from the light-sensitive area into the shielded storage area. A controller issues a command that asks for either a single transfer (one field into storage) or a flush (two full bursts back to back, which empties the image area). The block arms itself on the command and waits for the field-timing strobe, which marks the start of vertical blanking. It then emits the whole burst without a gap and reports completion with a one-cycle done strobe.

While no burst is running, the block also drives the anti-blooming gate with a square-wave burst whenever either horizontal or vertical blanking is active. During a transfer burst that output is held low. With the 14.31818 MHz system clock, one burst of 242 pulses at four clocks per pulse takes 968 clocks, about 67.6 µs. A flush takes 1936 clocks.

Top module: `vxfer_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `vclk`, `busy`, `done` and `abg` are all 0.
- R2: When idle, a `cmd_go` pulse sets `busy` on the next cycle. No `vclk` pulse appears until `fld_stb` is seen. While idle, `vclk` stays 0 and `fld_stb` has no effect.
- R3: The cycle after `fld_stb` is sampled while armed, `vclk` goes high. Each pulse is high for exactly 2 cycles and then low for exactly 2 cycles, with no gap between pulses.
- R4: A command with `cmd_flush`=0 produces exactly 242 `vclk` pulses, spanning 968 cycles from the first high cycle to the cycle before `done`.
- R5: A command with `cmd_flush`=1 produces exactly 484 `vclk` pulses in one unbroken train of 1936 cycles.
- R6: `done` is high for exactly one cycle, right after the low half of the final pulse. In that cycle `busy` is already 0.
- R7: A `cmd_go` that arrives while `busy` is high has no effect. This holds whether it comes before the strobe or during the burst: the pulse count and the mode stay those of the first command, and no further burst follows.
- R8: While the block is idle or armed and `hblank` or `vblank` is high, `abg` is a free-running square wave that is high 4 cycles and low 4 cycles, giving 8 high cycles in any 16. It is 0 when both blanking inputs are low.
- R9: `abg` is 0 on every cycle of a transfer burst, even with blanking active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_stb | input | 1 | Field-timing strobe; starts an armed burst |
| hblank | input | 1 | Horizontal blanking active |
| vblank | input | 1 | Vertical blanking active |
| cmd_go | input | 1 | One-cycle command request |
| cmd_flush | input | 1 | Selects the mode with `cmd_go`: 1 for flush, 0 for single transfer |
| vclk | output | 1 | Vertical transfer clock to the sensor |
| busy | output | 1 | Command accepted and not yet complete |
| done | output | 1 | One-cycle completion strobe |
| abg | output | 1 | Anti-blooming gate burst |

## Verification
`busy` is due one cycle after the command and the first `vclk` high one cycle after the strobe. `done` is due 4×N cycles after that first high cycle, where N is 242 or 484. `abg` responds in the same cycle as the blanking inputs. The bench drives every input on the falling edge and samples on the falling edge. It counts the observed cycles from the strobe and checks each result against the cycle number worked out from the requirements. A behavioural line counter, advanced on each rising `vclk`, stands in for the sensor and supplies the pulse totals.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic go;
        logic flush;
    } seq_cmd_t;

    // number of line-shift pulses a command asks for
    function automatic int unsigned burst_len(input logic flush, input int unsigned lines);
        return flush ? 2 * lines : lines;
    endfunction

endpackage

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl
    import vxfer_pkg::*;
#(
    parameter int unsigned LINES = 242,
    parameter int unsigned CW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_cmd_t      cmd,
    input  logic          fld_stb,
    input  logic          last,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] last_idx
);

    seq_state_t state_q, state_d;
    logic       flush_q, flush_d;
    logic       done_q, done_d;

    always_comb begin
        state_d = state_q;
        flush_d = flush_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd.go) begin
                    state_d = ST_ARMED;
                    flush_d = cmd.flush;
                end
            end
            ST_ARMED: begin
                if (fld_stb) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (last) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flush_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flush_q <= flush_d;
            done_q  <= done_d;
        end
    end

    assign run      = (state_q == ST_RUN);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign last_idx = CW'(burst_len(flush_q, LINES) - 1);

endmodule

// File: rtl/vxfer_pulse.sv
module vxfer_pulse #(
    parameter int unsigned HI_CYC = 2,
    parameter int unsigned LO_CYC = 2,
    parameter int unsigned CW     = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] last_idx,
    output logic          vclk,
    output logic          last
);

    localparam int unsigned PER = HI_CYC + LO_CYC;
    localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;

    logic [PW-1:0] phase_q;
    logic [CW-1:0] line_q;
    logic          wrap;

    assign wrap = (phase_q == PW'(PER - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
            line_q  <= '0;
        end else if (wrap) begin
            phase_q <= '0;
            line_q  <= line_q + 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign vclk = en && (phase_q < PW'(HI_CYC));
    assign last = en && wrap && (line_q == last_idx);

endmodule

// File: rtl/vxfer_abg.sv
module vxfer_abg #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic blank,
    input  logic hold,
    output logic abg
);

    localparam int unsigned DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DW-1:0] div_q;
    logic          sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            sq_q  <= 1'b0;
        end else if (div_q == DW'(HALF - 1)) begin
            div_q <= '0;
            sq_q  <= ~sq_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign abg = blank && !hold && sq_q;

endmodule

// File: rtl/vxfer_seq.sv
module vxfer_seq
    import vxfer_pkg::*;
#(
    parameter int unsigned LINES    = 242,
    parameter int unsigned HI_CYC   = 2,
    parameter int unsigned LO_CYC   = 2,
    parameter int unsigned ABG_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fld_stb,
    input  logic hblank,
    input  logic vblank,
    input  logic cmd_go,
    input  logic cmd_flush,
    output logic vclk,
    output logic busy,
    output logic done,
    output logic abg
);

    localparam int unsigned CW = $clog2(2 * LINES);

    seq_cmd_t      cmd;
    logic          run;
    logic          last;
    logic [CW-1:0] last_idx;

    assign cmd.go    = cmd_go;
    assign cmd.flush = cmd_flush;

    vxfer_ctrl #(.LINES(LINES), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .fld_stb  (fld_stb),
        .last     (last),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .last_idx (last_idx)
    );

    vxfer_pulse #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .CW(CW)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .en       (run),
        .last_idx (last_idx),
        .vclk     (vclk),
        .last     (last)
    );

    vxfer_abg #(.HALF(ABG_HALF)) u_abg (
        .clk   (clk),
        .rst   (rst),
        .blank (hblank || vblank),
        .hold  (run),
        .abg   (abg)
    );

endmodule

// File: rtl/vxfer_seq_chk.sv
module vxfer_seq_chk (
    input logic clk,
    input logic rst,
    input logic fld_stb,
    input logic hblank,
    input logic vblank,
    input logic cmd_go,
    input logic cmd_flush,
    input logic vclk,
    input logic busy,
    input logic done,
    input logic abg
);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !vclk);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_go) |=> busy);

    // R3
    hi_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vclk) |=> vclk);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    abg_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (!hblank && !vblank) |-> !abg);

    // R9
    abg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        vclk |-> !abg);

endmodule

bind vxfer_seq vxfer_seq_chk u_chk (.*);

// File: tb/vxfer_seq_test.sv
module vxfer_seq_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fld_stb = 1'b0, hblank = 1'b0, vblank = 1'b0;
    logic cmd_go = 1'b0, cmd_flush = 1'b0;
    logic vclk, busy, done, abg;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vxfer_seq uut (
        .clk(clk), .rst(rst), .fld_stb(fld_stb), .hblank(hblank), .vblank(vblank),
        .cmd_go(cmd_go), .cmd_flush(cmd_flush),
        .vclk(vclk), .busy(busy), .done(done), .abg(abg)
    );

    // vector: {flush, expected pulses}
    localparam logic [16:0] VEC [4] = '{
        {1'b0, 16'd242},
        {1'b1, 16'd484},
        {1'b0, 16'd242},
        {1'b1, 16'd484}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // issue a command, strobe, and follow the burst with a line-counter model
    task automatic do_xfer(input logic flush, input int exp_pulses,
                           input logic armed_cmd, input logic mid_cmd);
        int lines = 0, cyc = 0, hi_len = 0, lo_len = 0, bad_w = 0, abg_bad = 0;
        int pre_vclk = 0;
        logic prev = 1'b0;
        cmd_go = 1'b1; cmd_flush = flush;
        @(negedge clk);
        cmd_go = 1'b0; cmd_flush = 1'b0;
        check(busy == 1'b1, "R2 busy after command", busy, 1);
        for (int i = 0; i < 6; i++) begin
            if (i == 2 && armed_cmd) begin cmd_go = 1'b1; cmd_flush = ~flush; end
            if (i == 3) begin cmd_go = 1'b0; cmd_flush = 1'b0; end
            if (vclk) pre_vclk++;
            @(negedge clk);
        end
        check(pre_vclk == 0, "R2 no vclk before strobe", pre_vclk, 0);
        vblank = 1'b1;
        fld_stb = 1'b1;
        @(negedge clk);
        fld_stb = 1'b0;
        check(vclk == 1'b1, "R3 vclk high after strobe", vclk, 1);
        while (!done && cyc < 5000) begin
            if (vclk && !prev) begin
                lines++;
                if (lines > 1 && lo_len != 2) bad_w++;
                hi_len = 0;
            end
            if (!vclk && prev) begin
                if (hi_len != 2) bad_w++;
                lo_len = 0;
            end
            if (vclk) hi_len++; else lo_len++;
            if (abg) abg_bad++;
            prev = vclk;
            if (mid_cmd && cyc == 100) begin cmd_go = 1'b1; cmd_flush = ~flush; end
            if (mid_cmd && cyc == 101) begin cmd_go = 1'b0; cmd_flush = 1'b0; end
            cyc++;
            @(negedge clk);
        end
        if (lo_len != 2) bad_w++;
        check(lines == exp_pulses, flush ? "R5 flush pulse count" : "R4 single pulse count",
              lines, exp_pulses);
        check(cyc == 4 * exp_pulses, flush ? "R5 flush cycles" : "R4 single cycles",
              cyc, 4 * exp_pulses);
        check(bad_w == 0, "R3 pulse widths", bad_w, 0);
        check(abg_bad == 0, "R9 abg quiet during burst", abg_bad, 0);
        check(busy == 1'b0, "R6 busy clear with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", done, 0);
        vblank = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int highs;
        int stray;
        @(negedge clk);
        @(negedge clk);
        check({vclk, busy, done, abg} == 4'b0, "R1 outputs in reset", {vclk, busy, done, abg}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({vclk, busy, done, abg} == 4'b0, "R1 outputs after reset", {vclk, busy, done, abg}, 0);

        // R2: strobe while idle does nothing
        stray = 0;
        fld_stb = 1'b1;
        @(negedge clk);
        fld_stb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (vclk || busy) stray++;
            @(negedge clk);
        end
        check(stray == 0, "R2 idle strobe ignored", stray, 0);

        foreach (VEC[i]) begin
            do_xfer(VEC[i][16], int'(VEC[i][15:0]), 1'b0, 1'b0);
            repeat (3) @(negedge clk);
        end

        // R7: command while armed, then during the burst
        do_xfer(1'b0, 242, 1'b1, 1'b0);
        do_xfer(1'b0, 242, 1'b0, 1'b1);
        stray = 0;
        fld_stb = 1'b1;
        @(negedge clk);
        fld_stb = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (vclk || busy) stray++;
            @(negedge clk);
        end
        check(stray == 0, "R7 no burst from ignored command", stray, 0);

        // R8: anti-blooming bursts in blanking only
        hblank = 1'b1;
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            if (abg) highs++;
            @(negedge clk);
        end
        check(highs == 8, "R8 abg during hblank", highs, 8);
        hblank = 1'b0;
        vblank = 1'b1;
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            if (abg) highs++;
            @(negedge clk);
        end
        check(highs == 8, "R8 abg during vblank", highs, 8);
        vblank = 1'b0;
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            if (abg) highs++;
            @(negedge clk);
        end
        check(highs == 0, "R8 abg off outside blanking", highs, 0);

        summary();
        $finish;
    end

endmodule